// File: doc/BRIEF.md
# Rendezvous Message Channel Controller

This block joins one sending agent and one receiving agent for a synchronized, unbuffered message transfer. Each agent raises a one-cycle request carrying a channel address, a message pointer and a byte count. Whichever agent arrives first is held pending, with its operands captured, until its partner has also made a request for the same channel. No data is stored anywhere in the block. The bytes move straight from the sender's memory read port to the destination, one byte per clock. Both agents are then released together by a one-cycle done pulse.

The channel address alone picks the path. Addresses below the `LINK_BASE` parameter name point-to-point link channels, and their bytes leave on the link write port. Every other address is a word-based internal channel, and its bytes go to the receiver's memory write port. The request format is identical for both kinds, so an agent does not need to know where its channel is implemented.

Top module: `msg_rendezvous`

## Requirements
- R1: While reset is held and in the first cycle after reset, `snd_done`, `rcv_done`, `src_rd_en`, `dst_wr_en` and `lnk_wr_en` are all 0.
- R2: A side that has requested while its partner has not stays pending indefinitely. It sees no done pulse, and no read or write happens.
- R3: A transfer begins only when both sides are pending with equal channel addresses. Pending sides with different channel addresses never transfer and never complete.
- R4: A transfer moves min(send count, receive count) bytes, one per cycle. Byte k is read at send pointer + k and written at receive pointer + k, and the write data equals the read data of the same cycle.
- R5: If the sender's channel address is below `LINK_BASE`, every write of the transfer uses the link port. Otherwise every write uses the destination memory port. The two write enables are never high together.
- R6: If the transfer length is zero, the transfer completes with no read and no write.
- R7: `snd_done` and `rcv_done` pulse high together for exactly one cycle. The pulse is visible 1 + length cycles after the clock edge that captures the later of the two requests.
- R8: A request from a side that is already pending is ignored. The transfer uses the operands captured by that side's first request.
- R9: After its done pulse, a side accepts a new request on the next cycle, so transfers may follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_req | input | 1 | Sender request strobe (output operation) |
| snd_chan | input | AW | Sender channel address |
| snd_ptr | input | AW | Sender message pointer (source) |
| snd_cnt | input | CW | Sender byte count |
| snd_done | output | 1 | Sender release pulse |
| rcv_req | input | 1 | Receiver request strobe (input operation) |
| rcv_chan | input | AW | Receiver channel address |
| rcv_ptr | input | AW | Receiver message pointer (destination) |
| rcv_cnt | input | CW | Receiver byte count |
| rcv_done | output | 1 | Receiver release pulse |
| src_rd_en | output | 1 | Source memory read enable |
| src_rd_addr | output | AW | Source memory byte address |
| src_rd_data | input | 8 | Source memory read data, same cycle |
| dst_wr_en | output | 1 | Destination memory write enable (internal channel) |
| dst_wr_addr | output | AW | Destination memory byte address |
| dst_wr_data | output | 8 | Destination memory write data |
| lnk_wr_en | output | 1 | Link port write enable (external channel) |
| lnk_wr_addr | output | AW | Link port byte offset (receive pointer + k) |
| lnk_wr_data | output | 8 | Link port write data |

## Verification
The bench sweeps every pair of send and receive counts from 0 to 6 on both the internal and the link path. It checks the byte count against the smaller count, the contents at every offset, and the exact done cycle. A design that used one side's count, or that wrote one byte too many or too few, would corrupt the destination or release early. A design that gave a zero count a write cycle would show a spurious write. Separate cases keep a lone side waiting, re-request while pending, and offer mismatched channel addresses. These catch a design that releases without a partner, overwrites captured operands, or pairs different channels.

// File: rtl/msg_rdv_pkg.sv
package msg_rdv_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_MOVE = 2'd1,
    XF_FIN  = 2'd2
  } xf_state_e;

  // Number of bytes that actually move: the shorter of the two offers.
  function automatic int unsigned xfer_len(input int unsigned send_n,
                                           input int unsigned recv_n);
    return (send_n < recv_n) ? send_n : recv_n;
  endfunction

  // Channel addresses under the link base map onto the external link.
  function automatic logic is_link_chan(input int unsigned chan,
                                        input int unsigned base);
    return chan < base;
  endfunction

  // Address of byte k of a message.
  function automatic int unsigned byte_addr(input int unsigned base_ptr,
                                            input int unsigned k);
    return base_ptr + k;
  endfunction

endpackage

// File: rtl/rdv_port_hold.sv
// Captures one side's request operands and holds the side pending until release.
module rdv_port_hold #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] chan_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          release_i,
  output logic          pend_o,
  output logic          accept_o,
  output logic [AW-1:0] chan_o,
  output logic [AW-1:0] ptr_o,
  output logic [CW-1:0] cnt_o
);

  // A request is taken only by an idle side; repeats while pending fall away.
  assign accept_o = req_i && !pend_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      chan_o <= '0;
      ptr_o  <= '0;
      cnt_o  <= '0;
    end else if (release_i) begin
      pend_o <= 1'b0;
    end else if (accept_o) begin
      pend_o <= 1'b1;
      chan_o <= chan_i;
      ptr_o  <= ptr_i;
      cnt_o  <= cnt_i;
    end
  end

endmodule

// File: rtl/rdv_pair_match.sv
// Decides when the two pending sides form a rendezvous, and on which path.
module rdv_pair_match
  import msg_rdv_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 8,
  parameter int LINK_BASE = 16
) (
  input  logic          snd_pend_i,
  input  logic          rcv_pend_i,
  input  logic [AW-1:0] snd_chan_i,
  input  logic [AW-1:0] rcv_chan_i,
  input  logic [CW-1:0] snd_cnt_i,
  input  logic [CW-1:0] rcv_cnt_i,
  output logic          go_o,
  output logic [CW-1:0] len_o,
  output logic          link_o
);

  logic same_chan;

  assign same_chan = (snd_chan_i == rcv_chan_i);
  assign go_o      = snd_pend_i && rcv_pend_i && same_chan;
  assign len_o     = CW'(xfer_len(32'(snd_cnt_i), 32'(rcv_cnt_i)));
  assign link_o    = is_link_chan(32'(snd_chan_i), LINK_BASE);

endmodule

// File: rtl/rdv_byte_mover.sv
// Walks the source and destination pointers one byte per cycle.
module rdv_byte_mover
  import msg_rdv_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [CW-1:0]     len_i,
  input  logic              link_i,
  input  logic [AW-1:0]     src_ptr_i,
  input  logic [AW-1:0]     dst_ptr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              rd_en_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic              mem_wr_o,
  output logic              lnk_wr_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              move_o,
  output logic              fin_o
);

  xf_state_e     state_q;
  logic [AW-1:0] src_q;
  logic [AW-1:0] dst_q;
  logic [CW-1:0] left_q;
  logic          link_q;
  logic          last_beat;

  assign move_o    = (state_q == XF_MOVE);
  assign fin_o     = (state_q == XF_FIN);
  assign last_beat = move_o && (left_q == CW'(1));

  assign rd_en_o   = move_o;
  assign rd_addr_o = src_q;
  assign mem_wr_o  = move_o && !link_q;
  assign lnk_wr_o  = move_o && link_q;
  assign wr_addr_o = dst_q;
  assign wr_data_o = rd_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      left_q  <= '0;
      link_q  <= 1'b0;
    end else begin
      unique case (state_q)
        XF_IDLE: begin
          if (go_i) begin
            src_q   <= src_ptr_i;
            dst_q   <= dst_ptr_i;
            left_q  <= len_i;
            link_q  <= link_i;
            state_q <= (len_i == '0) ? XF_FIN : XF_MOVE;
          end
        end
        XF_MOVE: begin
          src_q  <= AW'(byte_addr(32'(src_q), 1));
          dst_q  <= AW'(byte_addr(32'(dst_q), 1));
          left_q <= left_q - CW'(1);
          if (last_beat) state_q <= XF_FIN;
        end
        XF_FIN:  state_q <= XF_IDLE;
        default: state_q <= XF_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/msg_rendezvous.sv
module msg_rendezvous
  import msg_rdv_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 8,
  parameter int LINK_BASE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snd_req,
  input  logic [AW-1:0] snd_chan,
  input  logic [AW-1:0] snd_ptr,
  input  logic [CW-1:0] snd_cnt,
  output logic          snd_done,
  input  logic          rcv_req,
  input  logic [AW-1:0] rcv_chan,
  input  logic [AW-1:0] rcv_ptr,
  input  logic [CW-1:0] rcv_cnt,
  output logic          rcv_done,
  output logic          src_rd_en,
  output logic [AW-1:0] src_rd_addr,
  input  logic [7:0]    src_rd_data,
  output logic          dst_wr_en,
  output logic [AW-1:0] dst_wr_addr,
  output logic [7:0]    dst_wr_data,
  output logic          lnk_wr_en,
  output logic [AW-1:0] lnk_wr_addr,
  output logic [7:0]    lnk_wr_data
);

  // Named internal events, visible to the bound checker.
  logic          snd_pend, rcv_pend;
  logic          snd_take, rcv_take;
  logic          xfer_go, xfer_move, xfer_fin, xfer_link;
  logic [CW-1:0] xfer_len_w;
  logic [AW-1:0] h_chan [2];
  logic [AW-1:0] h_ptr  [2];
  logic [CW-1:0] h_cnt  [2];
  logic [1:0]    side_req, side_pend, side_take;
  logic [AW-1:0] side_chan [2];
  logic [AW-1:0] side_ptr  [2];
  logic [CW-1:0] side_cnt  [2];
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  // Index 0 is the sending side, index 1 the receiving side.
  assign side_req  = {rcv_req, snd_req};
  assign side_chan[0] = snd_chan;
  assign side_chan[1] = rcv_chan;
  assign side_ptr[0]  = snd_ptr;
  assign side_ptr[1]  = rcv_ptr;
  assign side_cnt[0]  = snd_cnt;
  assign side_cnt[1]  = rcv_cnt;

  for (genvar s = 0; s < 2; s++) begin : g_side
    rdv_port_hold #(.AW(AW), .CW(CW)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (side_req[s]),
      .chan_i    (side_chan[s]),
      .ptr_i     (side_ptr[s]),
      .cnt_i     (side_cnt[s]),
      .release_i (xfer_fin),
      .pend_o    (side_pend[s]),
      .accept_o  (side_take[s]),
      .chan_o    (h_chan[s]),
      .ptr_o     (h_ptr[s]),
      .cnt_o     (h_cnt[s])
    );
  end

  assign snd_pend = side_pend[0];
  assign rcv_pend = side_pend[1];
  assign snd_take = side_take[0];
  assign rcv_take = side_take[1];

  rdv_pair_match #(.AW(AW), .CW(CW), .LINK_BASE(LINK_BASE)) u_match (
    .snd_pend_i (snd_pend),
    .rcv_pend_i (rcv_pend),
    .snd_chan_i (h_chan[0]),
    .rcv_chan_i (h_chan[1]),
    .snd_cnt_i  (h_cnt[0]),
    .rcv_cnt_i  (h_cnt[1]),
    .go_o       (xfer_go),
    .len_o      (xfer_len_w),
    .link_o     (xfer_link)
  );

  rdv_byte_mover #(.AW(AW), .CW(CW)) u_move (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (xfer_go),
    .len_i     (xfer_len_w),
    .link_i    (xfer_link),
    .src_ptr_i (h_ptr[0]),
    .dst_ptr_i (h_ptr[1]),
    .rd_data_i (src_rd_data),
    .rd_en_o   (src_rd_en),
    .rd_addr_o (src_rd_addr),
    .mem_wr_o  (dst_wr_en),
    .lnk_wr_o  (lnk_wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .move_o    (xfer_move),
    .fin_o     (xfer_fin)
  );

  assign dst_wr_addr = wr_addr;
  assign dst_wr_data = wr_data;
  assign lnk_wr_addr = wr_addr;
  assign lnk_wr_data = wr_data;
  assign snd_done    = xfer_fin;
  assign rcv_done    = xfer_fin;

endmodule

// File: rtl/msg_rendezvous_chk.sv
module msg_rendezvous_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          snd_done,
  input logic          rcv_done,
  input logic          snd_pend,
  input logic          rcv_pend,
  input logic          snd_take,
  input logic          rcv_take,
  input logic          src_rd_en,
  input logic [AW-1:0] src_rd_addr,
  input logic          dst_wr_en,
  input logic [AW-1:0] dst_wr_addr,
  input logic          lnk_wr_en
);

  assert_done_paired_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snd_done == rcv_done);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snd_done |=> !snd_done);

  assert_done_needs_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snd_done |-> (snd_pend && rcv_pend));

  assert_one_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dst_wr_en && lnk_wr_en));

  assert_write_needs_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr_en || lnk_wr_en || src_rd_en) |-> (snd_pend && rcv_pend));

  assert_dst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr_en && $past(dst_wr_en)) |-> (dst_wr_addr == $past(dst_wr_addr) + AW'(1)));

  assert_src_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd_en && $past(src_rd_en)) |-> (src_rd_addr == $past(src_rd_addr) + AW'(1)));

  assert_take_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_take || rcv_take) |=> $countones({snd_pend, rcv_pend}) >= 1);

  assert_no_retake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snd_pend |-> !snd_take);

endmodule

bind msg_rendezvous msg_rendezvous_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .snd_done    (snd_done),
  .rcv_done    (rcv_done),
  .snd_pend    (snd_pend),
  .rcv_pend    (rcv_pend),
  .snd_take    (snd_take),
  .rcv_take    (rcv_take),
  .src_rd_en   (src_rd_en),
  .src_rd_addr (src_rd_addr),
  .dst_wr_en   (dst_wr_en),
  .dst_wr_addr (dst_wr_addr),
  .lnk_wr_en   (lnk_wr_en)
);

// File: tb/sim_msg_rendezvous.sv
`timescale 1ns/1ps
module sim_msg_rendezvous;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int LB = 16;
  localparam logic [AW-1:0] CH_INT = 16'h0100;
  localparam logic [AW-1:0] CH_EXT = 16'h0004;

  logic clk = 1'b0;
  logic rst_n;
  logic snd_req, rcv_req;
  logic [AW-1:0] snd_chan, snd_ptr, rcv_chan, rcv_ptr;
  logic [CW-1:0] snd_cnt, rcv_cnt;
  logic snd_done, rcv_done;
  logic src_rd_en, dst_wr_en, lnk_wr_en;
  logic [AW-1:0] src_rd_addr, dst_wr_addr, lnk_wr_addr;
  logic [7:0] src_rd_data, dst_wr_data, lnk_wr_data;

  logic [7:0] smem [256];
  logic [7:0] dmem [256];
  logic [7:0] lmem [256];
  int dst_n, lnk_n, rd_n;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  msg_rendezvous #(.AW(AW), .CW(CW), .LINK_BASE(LB)) u0 (
    .clk(clk), .rst_n(rst_n),
    .snd_req(snd_req), .snd_chan(snd_chan), .snd_ptr(snd_ptr), .snd_cnt(snd_cnt),
    .snd_done(snd_done),
    .rcv_req(rcv_req), .rcv_chan(rcv_chan), .rcv_ptr(rcv_ptr), .rcv_cnt(rcv_cnt),
    .rcv_done(rcv_done),
    .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
    .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data),
    .lnk_wr_en(lnk_wr_en), .lnk_wr_addr(lnk_wr_addr), .lnk_wr_data(lnk_wr_data)
  );

  assign src_rd_data = smem[src_rd_addr[7:0]];

  always @(posedge clk) begin
    if (src_rd_en) rd_n = rd_n + 1;
    if (dst_wr_en) begin dmem[dst_wr_addr[7:0]] = dst_wr_data; dst_n = dst_n + 1; end
    if (lnk_wr_en) begin lmem[lnk_wr_addr[7:0]] = lnk_wr_data; lnk_n = lnk_n + 1; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mem(input int seed);
    for (int k = 0; k < 256; k++) begin
      smem[k] = 8'(k * 7 + seed);
      dmem[k] = 8'h00;
      lmem[k] = 8'h00;
    end
    dst_n = 0; lnk_n = 0; rd_n = 0;
  endtask

  task automatic do_reset();
    snd_req = 0; rcv_req = 0;
    snd_chan = '0; snd_ptr = '0; snd_cnt = '0;
    rcv_chan = '0; rcv_ptr = '0; rcv_cnt = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
  endtask

  // Both sides request in the same cycle; check timing, count and data.
  task automatic pair_xfer(input logic [AW-1:0] ch, input int sp, input int sc,
                           input int rp, input int rc);
    int len, done_at, done_n, pair_bad;
    bit ext;
    len = (sc < rc) ? sc : rc;
    ext = (ch < LB);
    clear_mem(sp + rc);
    @(negedge clk);
    snd_req = 1; snd_chan = ch; snd_ptr = AW'(sp); snd_cnt = CW'(sc);
    rcv_req = 1; rcv_chan = ch; rcv_ptr = AW'(rp); rcv_cnt = CW'(rc);
    done_at = 0; done_n = 0; pair_bad = 0;
    for (int i = 1; i <= len + 4; i++) begin
      @(posedge clk); #1;
      if (i == 1) begin snd_req = 0; rcv_req = 0; end
      if (snd_done != rcv_done) pair_bad++;
      if (snd_done) begin done_n++; if (done_at == 0) done_at = i; end
    end
    check(pair_bad == 0, "R7", "done sides disagree", pair_bad, 0);
    check(done_n == 1, "R7", "done pulse count", done_n, 1);
    check(done_at == len + 2, "R7", "done cycle", done_at, len + 2);
    if (ext) begin
      check(lnk_n == len, "R5", "link writes", lnk_n, len);
      check(dst_n == 0, "R5", "memory writes on link channel", dst_n, 0);
    end else begin
      check(dst_n == len, "R4", "memory writes", dst_n, len);
      check(lnk_n == 0, "R5", "link writes on internal channel", lnk_n, 0);
    end
    if (len == 0) check(rd_n == 0, "R6", "reads on empty transfer", rd_n, 0);
    for (int k = 0; k < len; k++) begin
      int got, exp;
      exp = smem[(sp + k) % 256];
      got = ext ? lmem[(rp + k) % 256] : dmem[(rp + k) % 256];
      check(got == exp, "R4", "byte value", got, exp);
    end
    // One byte past the end must be untouched.
    check((ext ? lmem[(rp + len) % 256] : dmem[(rp + len) % 256]) == 0,
          "R4", "byte past end", 1, 0);
  endtask

  initial begin
    #1_000_000;
    $display("FAIL watchdog: actual timeout expected finish");
    checks++; fails++;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int waited_bad;
    rst_n = 0;
    clear_mem(0);
    do_reset();
    // R1: reset state
    #1;
    check(!snd_done && !rcv_done, "R1", "done after reset", int'(snd_done), 0);
    check(!src_rd_en && !dst_wr_en && !lnk_wr_en, "R1", "access after reset",
          int'(dst_wr_en), 0);

    // R4 R5 R6 R7 R9: sweep counts on both paths, back to back without reset
    for (int p = 0; p < 2; p++)
      for (int sc = 0; sc <= 6; sc++)
        for (int rc = 0; rc <= 6; rc++)
          pair_xfer(p ? CH_EXT : CH_INT, 32 + sc * 5, sc, 128 + rc * 9, rc);

    // R2 and R8: sender waits alone, re-requests, then receiver arrives
    do_reset();
    clear_mem(3);
    @(negedge clk);
    snd_req = 1; snd_chan = CH_INT; snd_ptr = 16'd10; snd_cnt = 8'd3;
    @(negedge clk);
    snd_req = 0;
    waited_bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (snd_done || rcv_done || dst_wr_en || lnk_wr_en || src_rd_en) waited_bad++;
    end
    check(waited_bad == 0, "R2", "activity while partner absent", waited_bad, 0);
    snd_req = 1; snd_ptr = 16'd60; snd_cnt = 8'd5;   // must be ignored (R8)
    @(negedge clk);
    snd_req = 0;
    rcv_req = 1; rcv_chan = CH_INT; rcv_ptr = 16'd200; rcv_cnt = 8'd9;
    @(negedge clk);
    rcv_req = 0;
    repeat (8) @(negedge clk);
    check(dst_n == 3, "R8", "bytes after ignored re-request", dst_n, 3);
    for (int k = 0; k < 3; k++)
      check(dmem[200 + k] == smem[10 + k], "R8", "byte from first pointer",
            dmem[200 + k], smem[10 + k]);

    // R3: mismatched channel addresses never pair
    do_reset();
    clear_mem(5);
    @(negedge clk);
    snd_req = 1; snd_chan = CH_INT;          snd_ptr = 16'd4;  snd_cnt = 8'd2;
    rcv_req = 1; rcv_chan = CH_INT + 16'd1;  rcv_ptr = 16'd90; rcv_cnt = 8'd2;
    @(negedge clk);
    snd_req = 0; rcv_req = 0;
    waited_bad = 0;
    repeat (15) begin
      @(negedge clk);
      if (snd_done || rcv_done) waited_bad++;
    end
    check(waited_bad == 0, "R3", "done on mismatched channels", waited_bad, 0);
    check(dst_n + lnk_n == 0, "R3", "writes on mismatched channels", dst_n + lnk_n, 0);

    // R9: after reset, a fresh pair still completes
    do_reset();
    pair_xfer(CH_INT, 50, 4, 150, 4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule